// File: doc/BRIEF.md
# Calendar Date Counter with Leap Day Insertion

This block keeps the date of a clock/calendar as three BCD fields: day of month, month and a two-digit year (00 to 99). Each one-cycle pulse on the day-advance input, which a time-of-day counter raises at midnight, moves the date forward by one day. The block picks the length of each month from the month number. It adds a 29th day to February when the year is a leap year.

The leap test looks only at the two-digit year taken modulo 4. Year 00 therefore always counts as leap, and the century exceptions of the full calendar rule are deliberately not applied. A register interface writes each field through its own write strobe and data bus, and reads each field back from a plain output. Two one-cycle flags report a month carry and a year carry.

The advance input is a plain control pulse with no handshake. The block is always able to take it, so it never applies back-pressure. Write strobes are plain as well: each is taken in the cycle it is high.

Top module: `cal_date_counter`

## Requirements
- R1: After reset the fields read day 8'h01, month 8'h01 and year 8'h00, both carry flags read 0 and leap_o reads 1.
- R2: An advance pulse on a day below the month's last day raises the day by one in packed BCD (units in bits 3:0, tens in bits 7:4), so 8'h09 becomes 8'h10, and leaves the month and year unchanged. The new values appear one clock after the pulse.
- R3: Months 8'h04, 8'h06, 8'h09 and 8'h11 end at day 8'h30. Months 01, 03, 05, 07, 08, 10 and 12 end at day 8'h31.
- R4: February ends at day 8'h29 when the year value modulo 4 is 0, including year 00, and at day 8'h28 otherwise.
- R5: An advance pulse on the month's last day sets the day to 8'h01 and raises the month by one. In the cycle the new values appear, mon_carry_o is 1, for exactly one cycle.
- R6: An advance pulse on December's last day sets the month to 8'h01 and raises the year by one. yr_carry_o is 1 for that one cycle, together with mon_carry_o.
- R7: A year advance from 8'h99 gives year 8'h00.
- R8: When any write strobe is high, the advance pulse of that cycle is ignored. Each strobed field takes its write data one clock later, every other field keeps its value, and both carry flags are 0.
- R9: With no advance pulse and no write strobe, all fields hold their values and both carry flags are 0.
- R10: leap_o is 1 exactly when the current year value modulo 4 is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| day_adv_i | input | 1 | One-cycle pulse: advance the date by one day |
| day_we_i | input | 1 | Write strobe for the day field |
| day_wdata_i | input | 8 | BCD day to write |
| mon_we_i | input | 1 | Write strobe for the month field |
| mon_wdata_i | input | 8 | BCD month to write |
| yr_we_i | input | 1 | Write strobe for the year field |
| yr_wdata_i | input | 8 | BCD year to write |
| day_o | output | 8 | Current BCD day of month |
| mon_o | output | 8 | Current BCD month |
| yr_o | output | 8 | Current BCD two-digit year |
| leap_o | output | 1 | Current year is a leap year |
| mon_carry_o | output | 1 | One-cycle flag: the last advance wrapped the day |
| yr_carry_o | output | 1 | One-cycle flag: the last advance wrapped the month |

## Verification
A wrong month-length or leap decision inside the block shows up on the day a month should end. The day output then either goes to a 29, 30 or 31 that should not exist, or wraps early, and the mismatch appears one clock after that advance pulse. A broken BCD digit carry shows up within ten advances as a non-decimal units digit. A bad year-parity test shows up in the first February of an affected year. The bench steps through a full hundred-year cycle one day at a time and compares every field and flag after every advance, so each such fault is reported on the first day it changes the date.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int BCD_W   = 8;
  localparam int DIGIT_W = 4;

  typedef logic [BCD_W-1:0] bcd2_t;

  // Two-digit BCD increment; 99 rolls to 00.
  function automatic bcd2_t bcd2_inc(input bcd2_t v);
    bcd2_t r;
    if (v[DIGIT_W-1:0] >= 4'd9) begin
      r[DIGIT_W-1:0] = 4'd0;
      if (v[BCD_W-1:DIGIT_W] >= 4'd9) r[BCD_W-1:DIGIT_W] = 4'd0;
      else r[BCD_W-1:DIGIT_W] = v[BCD_W-1:DIGIT_W] + 4'd1;
    end else begin
      r[DIGIT_W-1:0]     = v[DIGIT_W-1:0] + 4'd1;
      r[BCD_W-1:DIGIT_W] = v[BCD_W-1:DIGIT_W];
    end
    return r;
  endfunction

  // Year mod 4 from BCD digits: (10*t + u) mod 4 = (2*t + u) mod 4.
  function automatic logic year_is_leap(input bcd2_t y);
    logic [1:0] m4;
    m4 = {y[DIGIT_W], 1'b0} + y[1:0];
    return (m4 == 2'd0);
  endfunction

  // Last day of the month, BCD.
  function automatic bcd2_t month_last_day(input bcd2_t mon, input logic leap);
    bcd2_t r;
    case (mon)
      8'h02:                      r = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: r = 8'h30;
      default:                    r = 8'h31;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/cal_year_field.sv
module cal_year_field
  import cal_pkg::*;
#(
  parameter bcd2_t RST_VAL = 8'h00
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  inc_en,
  input  logic  wr,
  input  bcd2_t wdata,
  output bcd2_t yr,
  output logic  leap
);
  bcd2_t yr_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      yr_q <= RST_VAL;
    else if (wr)     yr_q <= wdata;
    else if (inc_en) yr_q <= bcd2_inc(yr_q);
  end

  assign yr   = yr_q;
  assign leap = year_is_leap(yr_q);

  assert_yr_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_en && !wr && yr_q == 8'h99) |=> (yr_q == 8'h00));
  assert_yr_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (yr_q == $past(wdata)));
  assert_yr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr && !inc_en) |=> $stable(yr_q));
endmodule

// File: rtl/cal_month_field.sv
module cal_month_field
  import cal_pkg::*;
#(
  parameter bcd2_t RST_VAL  = 8'h01,
  parameter bcd2_t LAST_MON = 8'h12
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  inc_en,
  input  logic  wr,
  input  bcd2_t wdata,
  output bcd2_t mon,
  output logic  wrap
);
  bcd2_t mon_q;
  logic  at_end;

  assign at_end = (mon_q >= LAST_MON);
  assign wrap   = inc_en && at_end;

  always_ff @(posedge clk) begin
    if (!rst_n)      mon_q <= RST_VAL;
    else if (wr)     mon_q <= wdata;
    else if (wrap)   mon_q <= 8'h01;
    else if (inc_en) mon_q <= bcd2_inc(mon_q);
  end

  assign mon = mon_q;

  assert_mon_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_en && !wr && mon_q == LAST_MON) |=> (mon_q == 8'h01));
  assert_mon_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (mon_q == $past(wdata)));
  assert_mon_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr && !inc_en) |=> $stable(mon_q));
endmodule

// File: rtl/cal_day_field.sv
module cal_day_field
  import cal_pkg::*;
#(
  parameter bcd2_t RST_VAL = 8'h01
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  adv_en,
  input  logic  wr,
  input  bcd2_t wdata,
  input  bcd2_t last_day,
  output bcd2_t day,
  output logic  wrap
);
  bcd2_t day_q;

  assign wrap = adv_en && (day_q >= last_day);

  always_ff @(posedge clk) begin
    if (!rst_n)      day_q <= RST_VAL;
    else if (wr)     day_q <= wdata;
    else if (wrap)   day_q <= 8'h01;
    else if (adv_en) day_q <= bcd2_inc(day_q);
  end

  assign day = day_q;

  assert_day_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !wr) |=> (day_q == 8'h01));
  assert_day_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_en && !wr && day_q < last_day) |=> (day_q > $past(day_q)));
  assert_day_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (day_q == $past(wdata)));
  assert_day_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr && !adv_en) |=> $stable(day_q));
endmodule

// File: rtl/cal_date_counter.sv
module cal_date_counter
  import cal_pkg::*;
#(
  parameter logic [7:0] RST_DAY  = 8'h01,
  parameter logic [7:0] RST_MON  = 8'h01,
  parameter logic [7:0] RST_YEAR = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       day_adv_i,
  input  logic       day_we_i,
  input  logic [7:0] day_wdata_i,
  input  logic       mon_we_i,
  input  logic [7:0] mon_wdata_i,
  input  logic       yr_we_i,
  input  logic [7:0] yr_wdata_i,
  output logic [7:0] day_o,
  output logic [7:0] mon_o,
  output logic [7:0] yr_o,
  output logic       leap_o,
  output logic       mon_carry_o,
  output logic       yr_carry_o
);
  logic  any_we, adv_ok;
  logic  day_wrap, mon_wrap, leap_w;
  bcd2_t day_w, mon_w, yr_w, last_day;
  logic  mon_carry_q, yr_carry_q;

  assign any_we   = day_we_i | mon_we_i | yr_we_i;
  assign adv_ok   = day_adv_i & ~any_we;
  assign last_day = month_last_day(mon_w, leap_w);

  cal_day_field #(.RST_VAL(RST_DAY)) u_day (
    .clk(clk), .rst_n(rst_n), .adv_en(adv_ok), .wr(day_we_i),
    .wdata(day_wdata_i), .last_day(last_day), .day(day_w), .wrap(day_wrap)
  );

  cal_month_field #(.RST_VAL(RST_MON), .LAST_MON(8'h12)) u_mon (
    .clk(clk), .rst_n(rst_n), .inc_en(day_wrap), .wr(mon_we_i),
    .wdata(mon_wdata_i), .mon(mon_w), .wrap(mon_wrap)
  );

  cal_year_field #(.RST_VAL(RST_YEAR)) u_yr (
    .clk(clk), .rst_n(rst_n), .inc_en(mon_wrap), .wr(yr_we_i),
    .wdata(yr_wdata_i), .yr(yr_w), .leap(leap_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mon_carry_q <= 1'b0;
      yr_carry_q  <= 1'b0;
    end else begin
      mon_carry_q <= day_wrap;
      yr_carry_q  <= mon_wrap;
    end
  end

  assign day_o       = day_w;
  assign mon_o       = mon_w;
  assign yr_o        = yr_w;
  assign leap_o      = leap_w;
  assign mon_carry_o = mon_carry_q;
  assign yr_carry_o  = yr_carry_q;

  assert_yr_carry_pairs_R6: assert property (@(posedge clk) disable iff (!rst_n)
    yr_carry_o |-> (mon_carry_o && mon_o == 8'h01 && day_o == 8'h01));
  assert_mon_carry_day1_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mon_carry_o |-> (day_o == 8'h01));
  assert_write_no_carry_R8: assert property (@(posedge clk) disable iff (!rst_n)
    any_we |=> (!mon_carry_o && !yr_carry_o));
  assert_feb_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_ok && mon_o == 8'h02 && day_o == 8'h28 && !leap_o) |=> (mon_o == 8'h03));
endmodule

// File: tb/cal_date_counter_tb.sv
module cal_date_counter_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       day_adv_i = 1'b0;
  logic       day_we_i = 1'b0, mon_we_i = 1'b0, yr_we_i = 1'b0;
  logic [7:0] day_wdata_i = 8'h00, mon_wdata_i = 8'h00, yr_wdata_i = 8'h00;
  logic [7:0] day_o, mon_o, yr_o;
  logic       leap_o, mon_carry_o, yr_carry_o;

  int vecs = 0;
  int errs = 0;
  int ed, em, ey;
  logic emc, eyc;

  always #2 clk = ~clk;

  cal_date_counter u_dut (
    .clk(clk), .rst_n(rst_n), .day_adv_i(day_adv_i),
    .day_we_i(day_we_i), .day_wdata_i(day_wdata_i),
    .mon_we_i(mon_we_i), .mon_wdata_i(mon_wdata_i),
    .yr_we_i(yr_we_i), .yr_wdata_i(yr_wdata_i),
    .day_o(day_o), .mon_o(mon_o), .yr_o(yr_o), .leap_o(leap_o),
    .mon_carry_o(mon_carry_o), .yr_carry_o(yr_carry_o)
  );

  function automatic logic [7:0] to_bcd(input int n);
    return 8'((n / 10) * 16 + (n % 10));
  endfunction

  function automatic int days_in(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic chk8(input string req, input logic [7:0] act, input logic [7:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %h expected %h (date %0d-%0d-%0d)", req, act, exp, ey, em, ed);
    end
  endtask

  task automatic check_all(input string tag);
    chk8({tag, " R2 R3 R4 day"}, day_o, to_bcd(ed));
    chk8({tag, " R5 month"}, mon_o, to_bcd(em));
    chk8({tag, " R6 R7 year"}, yr_o, to_bcd(ey));
    chk8({tag, " R10 leap"}, {7'd0, leap_o}, {7'd0, (ey % 4 == 0)});
    chk8({tag, " R5 mon_carry"}, {7'd0, mon_carry_o}, {7'd0, emc});
    chk8({tag, " R6 yr_carry"}, {7'd0, yr_carry_o}, {7'd0, eyc});
  endtask

  // One clock with the given inputs; model updated; outputs checked after the edge.
  task automatic step(input logic adv, input logic dw, input int dv,
                      input logic mw, input int mv, input logic yw, input int yv,
                      input string tag);
    @(negedge clk);
    day_adv_i = adv;
    day_we_i = dw; day_wdata_i = to_bcd(dv);
    mon_we_i = mw; mon_wdata_i = to_bcd(mv);
    yr_we_i  = yw; yr_wdata_i  = to_bcd(yv);
    emc = 1'b0; eyc = 1'b0;
    if (dw || mw || yw) begin
      if (dw) ed = dv;
      if (mw) em = mv;
      if (yw) ey = yv;
    end else if (adv) begin
      if (ed >= days_in(em, ey)) begin
        ed = 1; emc = 1'b1;
        if (em >= 12) begin
          em = 1; eyc = 1'b1;
          ey = (ey + 1) % 100;
        end else em = em + 1;
      end else ed = ed + 1;
    end
    @(posedge clk);
    #1;
    day_adv_i = 1'b0; day_we_i = 1'b0; mon_we_i = 1'b0; yr_we_i = 1'b0;
    check_all(tag);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    ed = 1; em = 1; ey = 0; emc = 1'b0; eyc = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check_all("R1 reset");

    // R9: idle cycles hold everything
    for (int i = 0; i < 5; i++) step(1'b0, 1'b0, 0, 1'b0, 0, 1'b0, 0, "R9 hold");

    // R2..R7, R10: one hundred full years, day by day, ends back at 00-01-01
    for (int n = 0; n < 36525; n++) step(1'b1, 1'b0, 0, 1'b0, 0, 1'b0, 0, "sweep");
    chk8("R7 century wrap day", day_o, 8'h01);
    chk8("R7 century wrap year", yr_o, 8'h00);

    // R8: write beats advance, other fields untouched
    step(1'b1, 1'b0, 0, 1'b1, 5, 1'b0, 0, "R8 mon write with adv");
    step(1'b1, 1'b1, 31, 1'b0, 0, 1'b0, 0, "R8 day write with adv");
    step(1'b1, 1'b0, 0, 1'b0, 0, 1'b1, 47, "R8 year write with adv");
    step(1'b1, 1'b0, 0, 1'b0, 0, 1'b0, 0, "R5 May 31 wrap");
    step(1'b0, 1'b0, 0, 1'b0, 0, 1'b0, 0, "R9 hold after carry");

    // R4: leap February in 48, plain in 47
    step(1'b0, 1'b1, 28, 1'b1, 2, 1'b1, 48, "R8 load Feb 28 48");
    step(1'b1, 1'b0, 0, 1'b0, 0, 1'b0, 0, "R4 leap Feb 29");
    step(1'b1, 1'b0, 0, 1'b0, 0, 1'b0, 0, "R4 leap Mar 1");
    step(1'b0, 1'b1, 28, 1'b1, 2, 1'b1, 47, "R8 load Feb 28 47");
    step(1'b1, 1'b0, 0, 1'b0, 0, 1'b0, 0, "R4 plain Mar 1");

    // R7: 99-12-31 rolls to 00-01-01 with both carries
    step(1'b0, 1'b1, 31, 1'b1, 12, 1'b1, 99, "R8 load 99-12-31");
    step(1'b1, 1'b0, 0, 1'b0, 0, 1'b0, 0, "R7 year 99 wrap");

    // R1: reset again mid-date
    step(1'b0, 1'b1, 17, 1'b1, 9, 1'b1, 33, "R8 load 33-09-17");
    @(negedge clk);
    rst_n = 1'b0;
    @(posedge clk);
    #1;
    ed = 1; em = 1; ey = 0; emc = 1'b0; eyc = 1'b0;
    check_all("R1 re-reset");
    @(negedge clk);
    rst_n = 1'b1;

    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule